// File: doc/BRIEF.md
# Processor Mode and Exception Entry Controller

This block holds the privilege mode, the instruction-set state bit, the interrupt masks and the condition flags of a simple RISC core. When an exception request arrives it picks the most urgent one and switches to that exception's fixed target mode. In the same clock edge it stores the return address and the old status word in that mode's banked registers and sets the masks. One cycle later it presents the vector address to the fetch unit.

Two other ports change the state. The status write port lets privileged software change the mode, which is the only way to enter system mode. It also sets the masks and flags. An interworking branch port takes a target address whose lowest bit selects between the 16-bit compact state and the 32-bit wide state. That bit is removed from the address that goes to the fetch unit. All outputs come from registers. The state changes on the clock edge that samples the request.

Top module: `excp_mode_ctrl`

## Requirements
- R1: When rst_ni is asserted, the block enters supervisor mode (10011) with I and F set, T clear and flags zero. All banked registers are cleared, pc_load_o is low, and status_o reads 0x000000D3.
- R2: priv_o is low in user mode (10000) and high in every other mode.
- R3: An exception request moves mode_o to its target mode on the edge that samples it. Targets: reset request and software interrupt go to supervisor 10011, prefetch abort and data abort go to abort 10111, undefined instruction goes to undefined 11011, IRQ goes to 10010 and FIQ goes to 10001.
- R4: When several requests are active together, only one is taken. The order is reset first, then data abort, FIQ, IRQ, prefetch abort, undefined and software interrupt last.
- R5: irq_i is ignored while the I mask is set, and fiq_i is ignored while the F mask is set.
- R6: On entry, pc_i minus 4 is written into the target mode's link register and the pre-entry status word into its saved-status register. lr_o and spsr_o show the banks of the current mode and read zero in user and system mode.
- R7: Entry sets I and clears T. F is set on reset and FIQ entry and is unchanged for other kinds.
- R8: The cycle after an exception, pc_load_o is high for one cycle. pc_o then carries the vector: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R9: The status word is laid out as flags in [31:28], I in [7], F in [6], T in [5] and mode in [4:0], with other bits reading zero. From a privileged mode a write updates the flags, I, F and mode, so a mode value of 11111 enters system mode. T is never changed by a write.
- R10: A status write made in user mode updates only the flags. Mode, I and F keep their values.
- R11: A status write whose mode field is not one of the seven legal encodings leaves the mode unchanged. Its other fields still apply.
- R12: An interworking branch sets T to bit 0 of bx_target_i. The cycle after, pc_load_o is high and pc_o is the target with bit 0 cleared.
- R13: An exception taken in the same cycle as a status write or a branch discards both. A status write and a branch in the same cycle without an exception both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_rst_i | input | 1 | Reset exception request |
| req_swi_i | input | 1 | Software interrupt request |
| req_und_i | input | 1 | Undefined instruction request |
| req_pabt_i | input | 1 | Prefetch abort request |
| req_dabt_i | input | 1 | Data abort request |
| irq_i | input | 1 | Normal interrupt request |
| fiq_i | input | 1 | Fast interrupt request |
| pc_i | input | AW | Current program counter |
| sr_we_i | input | 1 | Status write strobe |
| sr_wdata_i | input | 32 | Status write data |
| bx_valid_i | input | 1 | Interworking branch strobe |
| bx_target_i | input | AW | Branch target, bit 0 selects compact state |
| mode_o | output | 5 | Current mode |
| priv_o | output | 1 | Privileged flag |
| thumb_o | output | 1 | Compact instruction state |
| irq_mask_o | output | 1 | I mask |
| fiq_mask_o | output | 1 | F mask |
| status_o | output | 32 | Current status word |
| lr_o | output | AW | Link register of current mode |
| spsr_o | output | 32 | Saved status of current mode |
| pc_load_o | output | 1 | New PC valid |
| pc_o | output | AW | Vector or branch target |

## Verification
An exception request can arrive in the same cycle as a status write or an interworking branch, and the three functions compete for the same state. The directed part provokes this by issuing a software interrupt together with a write to system mode and a compact-state branch. The random part also raises these strobes independently and sometimes lands them in the same cycle. Each result is judged against a bench model: when an exception coincides with a write or branch, only the exception may leave a trace in mode, T, masks and pc_o. A write and a branch without an exception must both show their effects.

// File: rtl/excp_mode_pkg.sv
package excp_mode_pkg;

  localparam int NUM_EXC = 7;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W = 3;

  typedef enum logic [4:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } mode_e;

  // index order is the priority order, 0 highest
  typedef enum logic [2:0] {
    EXC_RST  = 3'd0,
    EXC_DABT = 3'd1,
    EXC_FIQ  = 3'd2,
    EXC_IRQ  = 3'd3,
    EXC_PABT = 3'd4,
    EXC_UND  = 3'd5,
    EXC_SWI  = 3'd6
  } exc_e;

  typedef struct packed {
    logic [3:0]  flags;
    logic [19:0] rsvd;
    logic        i;
    logic        f;
    logic        t;
    logic [4:0]  mode;
  } status_t;

  function automatic logic mode_legal(input logic [4:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: mode_legal = 1'b1;
      default:                      mode_legal = 1'b0;
    endcase
  endfunction

  // user and system share the unbanked registers: no bank index
  function automatic logic [BANK_W-1:0] mode_bank(input logic [4:0] m);
    case (m)
      MODE_SVC: mode_bank = BANK_W'(0);
      MODE_ABT: mode_bank = BANK_W'(1);
      MODE_UND: mode_bank = BANK_W'(2);
      MODE_IRQ: mode_bank = BANK_W'(3);
      MODE_FIQ: mode_bank = BANK_W'(4);
      default:  mode_bank = BANK_W'(NUM_BANKS);
    endcase
  endfunction

endpackage

// File: rtl/excp_prio_arb.sv
module excp_prio_arb #(
  parameter int N = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  gnt_o
);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    gnt_o   = '0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && !valid_o) begin
        valid_o  = 1'b1;
        idx_o    = IW'(k);
        gnt_o[k] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/excp_vector_map.sv
module excp_vector_map
  import excp_mode_pkg::*;
(
  input  exc_e       kind_i,
  output logic [4:0] mode_o,
  output logic [4:0] vec_ofs_o,
  output logic       set_f_o
);

  always_comb begin
    set_f_o = 1'b0;
    case (kind_i)
      EXC_RST:  begin mode_o = MODE_SVC; vec_ofs_o = 5'h00; set_f_o = 1'b1; end
      EXC_DABT: begin mode_o = MODE_ABT; vec_ofs_o = 5'h10; end
      EXC_FIQ:  begin mode_o = MODE_FIQ; vec_ofs_o = 5'h1C; set_f_o = 1'b1; end
      EXC_IRQ:  begin mode_o = MODE_IRQ; vec_ofs_o = 5'h18; end
      EXC_PABT: begin mode_o = MODE_ABT; vec_ofs_o = 5'h0C; end
      EXC_UND:  begin mode_o = MODE_UND; vec_ofs_o = 5'h04; end
      EXC_SWI:  begin mode_o = MODE_SVC; vec_ofs_o = 5'h08; end
      default:  begin mode_o = MODE_SVC; vec_ofs_o = 5'h00; end
    endcase
  end

endmodule

// File: rtl/excp_bank_file.sv
module excp_bank_file #(
  parameter int AW = 32,
  parameter int SW = 32,
  parameter int NB = 5,
  parameter int BW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [BW-1:0] wr_bank_i,
  input  logic [AW-1:0] wr_lr_i,
  input  logic [SW-1:0] wr_sr_i,
  input  logic [BW-1:0] rd_bank_i,
  output logic [AW-1:0] rd_lr_o,
  output logic [SW-1:0] rd_sr_o
);

  logic [AW-1:0] lr_arr [NB];
  logic [SW-1:0] sr_arr [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [AW-1:0] lr_q;
    logic [SW-1:0] sr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lr_q <= '0;
        sr_q <= '0;
      end else if (wr_en_i && (wr_bank_i == BW'(b))) begin
        lr_q <= wr_lr_i;
        sr_q <= wr_sr_i;
      end
    end

    assign lr_arr[b] = lr_q;
    assign sr_arr[b] = sr_q;
  end

  always_comb begin
    rd_lr_o = '0;
    rd_sr_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (rd_bank_i == BW'(b)) begin
        rd_lr_o = lr_arr[b];
        rd_sr_o = sr_arr[b];
      end
    end
  end

endmodule

// File: rtl/excp_mode_ctrl.sv
module excp_mode_ctrl
  import excp_mode_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          LINK_OFS = 4,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_rst_i,
  input  logic          req_swi_i,
  input  logic          req_und_i,
  input  logic          req_pabt_i,
  input  logic          req_dabt_i,
  input  logic          irq_i,
  input  logic          fiq_i,
  input  logic [AW-1:0] pc_i,
  input  logic          sr_we_i,
  input  logic [31:0]   sr_wdata_i,
  input  logic          bx_valid_i,
  input  logic [AW-1:0] bx_target_i,
  output logic [4:0]    mode_o,
  output logic          priv_o,
  output logic          thumb_o,
  output logic          irq_mask_o,
  output logic          fiq_mask_o,
  output logic [31:0]   status_o,
  output logic [AW-1:0] lr_o,
  output logic [31:0]   spsr_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_o
);

  localparam int IW = $clog2(NUM_EXC);

  status_t       sr_q, sr_d, wr_sr;
  logic [NUM_EXC-1:0] exc_req, exc_gnt;
  logic          exc_take;
  logic [IW-1:0] exc_idx;
  logic [4:0]    tgt_mode, vec_ofs;
  logic          tgt_set_f;
  logic          load_d;
  logic [AW-1:0] pc_d;

  assign exc_req[EXC_RST]  = req_rst_i;
  assign exc_req[EXC_DABT] = req_dabt_i;
  assign exc_req[EXC_FIQ]  = fiq_i & ~sr_q.f;
  assign exc_req[EXC_IRQ]  = irq_i & ~sr_q.i;
  assign exc_req[EXC_PABT] = req_pabt_i;
  assign exc_req[EXC_UND]  = req_und_i;
  assign exc_req[EXC_SWI]  = req_swi_i;

  excp_prio_arb #(.N(NUM_EXC)) i_arb (
    .req_i   (exc_req),
    .valid_o (exc_take),
    .idx_o   (exc_idx),
    .gnt_o   (exc_gnt)
  );

  excp_vector_map i_map (
    .kind_i    (exc_e'(exc_idx)),
    .mode_o    (tgt_mode),
    .vec_ofs_o (vec_ofs),
    .set_f_o   (tgt_set_f)
  );

  assign wr_sr = status_t'(sr_wdata_i);

  always_comb begin
    sr_d   = sr_q;
    load_d = 1'b0;
    pc_d   = pc_o;
    if (exc_take) begin
      sr_d.mode = tgt_mode;
      sr_d.i    = 1'b1;
      sr_d.t    = 1'b0;
      if (tgt_set_f) sr_d.f = 1'b1;
      load_d = 1'b1;
      pc_d   = AW'(VEC_BASE) + AW'(vec_ofs);
    end else begin
      if (sr_we_i) begin
        sr_d.flags = wr_sr.flags;
        if (sr_q.mode != MODE_USR) begin
          sr_d.i = wr_sr.i;
          sr_d.f = wr_sr.f;
          if (mode_legal(wr_sr.mode)) sr_d.mode = wr_sr.mode;
        end
      end
      if (bx_valid_i) begin
        sr_d.t = bx_target_i[0];
        load_d = 1'b1;
        pc_d   = {bx_target_i[AW-1:1], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '{flags: 4'h0, rsvd: 20'h0, i: 1'b1, f: 1'b1, t: 1'b0, mode: MODE_SVC};
      pc_load_o <= 1'b0;
      pc_o      <= '0;
    end else begin
      sr_q      <= sr_d;
      pc_load_o <= load_d;
      pc_o      <= pc_d;
    end
  end

  excp_bank_file #(.AW(AW), .SW(32), .NB(NUM_BANKS), .BW(BANK_W)) i_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (exc_take),
    .wr_bank_i (mode_bank(tgt_mode)),
    .wr_lr_i   (pc_i - AW'(LINK_OFS)),
    .wr_sr_i   (sr_q),
    .rd_bank_i (mode_bank(sr_q.mode)),
    .rd_lr_o   (lr_o),
    .rd_sr_o   (spsr_o)
  );

  assign mode_o     = sr_q.mode;
  assign priv_o     = (sr_q.mode != MODE_USR);
  assign thumb_o    = sr_q.t;
  assign irq_mask_o = sr_q.i;
  assign fiq_mask_o = sr_q.f;
  assign status_o   = sr_q;

endmodule

// File: rtl/excp_mode_ctrl_chk.sv
module excp_mode_ctrl_chk #(
  parameter int          AW       = 32,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_rst_i,
  input logic          req_swi_i,
  input logic          req_und_i,
  input logic          req_pabt_i,
  input logic          req_dabt_i,
  input logic          irq_i,
  input logic          fiq_i,
  input logic [AW-1:0] pc_i,
  input logic          sr_we_i,
  input logic [31:0]   sr_wdata_i,
  input logic          bx_valid_i,
  input logic [AW-1:0] bx_target_i,
  input logic [4:0]    mode_o,
  input logic          priv_o,
  input logic          thumb_o,
  input logic          irq_mask_o,
  input logic          fiq_mask_o,
  input logic [31:0]   status_o,
  input logic [AW-1:0] lr_o,
  input logic [31:0]   spsr_o,
  input logic          pc_load_o,
  input logic [AW-1:0] pc_o
);

  logic any_exc;
  assign any_exc = req_rst_i | req_dabt_i | req_pabt_i | req_und_i | req_swi_i |
                   (irq_i & ~irq_mask_o) | (fiq_i & ~fiq_mask_o);

  assert_rst_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_rst_i |=> (mode_o == 5'h13) && irq_mask_o && fiq_mask_o && pc_load_o &&
                  (pc_o == AW'(VEC_BASE)));

  assert_dabt_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_dabt_i && !req_rst_i) |=> (mode_o == 5'h17) && pc_load_o &&
                                   (pc_o == AW'(VEC_BASE) + AW'(32'h10)));

  assert_irq_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && irq_mask_o && !req_rst_i && !req_dabt_i && !req_pabt_i && !req_und_i &&
     !req_swi_i && !(fiq_i && !fiq_mask_o) && !sr_we_i) |=> $stable(mode_o));

  assert_entry_masks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_exc |=> irq_mask_o && !thumb_o);

  assert_sys_by_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_we_i && mode_o != 5'h1F) |=> mode_o != 5'h1F);

  assert_user_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_we_i && mode_o == 5'h10 && !any_exc) |=> (mode_o == 5'h10) && $stable(irq_mask_o) &&
                                                $stable(fiq_mask_o));

  assert_unbanked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 5'h10 || mode_o == 5'h1F) |-> (lr_o == '0) && (spsr_o == '0));

  assert_user_unpriv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4:0] == 5'h10) |-> !priv_o);

  assert_branch_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bx_valid_i && !any_exc) |=> pc_load_o && !pc_o[0] && (thumb_o == $past(bx_target_i[0])));

endmodule

bind excp_mode_ctrl excp_mode_ctrl_chk #(.AW(AW), .VEC_BASE(VEC_BASE)) i_chk (.*);

// File: tb/test_excp_mode_ctrl.sv
module test_excp_mode_ctrl;
  localparam int AW = 32;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_rst = 0, req_swi = 0, req_und = 0, req_pabt = 0, req_dabt = 0, irq = 0, fiq = 0;
  logic [AW-1:0] pc_in = '0, bx_tgt = '0;
  logic sr_we = 0, bx_v = 0;
  logic [31:0] sr_wd = '0;
  logic [4:0] mode;
  logic priv, thumb, imask, fmask, pc_load;
  logic [31:0] status, spsr;
  logic [AW-1:0] lr, pc_out;

  always #(CLK_P/2) clk = ~clk;

  excp_mode_ctrl #(.AW(AW)) i_excp_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_rst_i(req_rst), .req_swi_i(req_swi), .req_und_i(req_und),
    .req_pabt_i(req_pabt), .req_dabt_i(req_dabt), .irq_i(irq), .fiq_i(fiq), .pc_i(pc_in),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wd), .bx_valid_i(bx_v), .bx_target_i(bx_tgt),
    .mode_o(mode), .priv_o(priv), .thumb_o(thumb), .irq_mask_o(imask), .fiq_mask_o(fmask),
    .status_o(status), .lr_o(lr), .spsr_o(spsr), .pc_load_o(pc_load), .pc_o(pc_out)
  );

  int n_chk = 0, n_fail = 0;

  // reference model
  logic [4:0] m_mode;
  logic m_i, m_f, m_t;
  logic [3:0] m_flags;
  logic [AW-1:0] m_lr [5];
  logic [31:0] m_spsr [5];

  function automatic logic legal(input logic [4:0] m);
    return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
           m == 5'h17 || m == 5'h1B || m == 5'h1F;
  endfunction

  function automatic int bank(input logic [4:0] m);
    case (m)
      5'h13: return 0;
      5'h17: return 1;
      5'h1B: return 2;
      5'h12: return 3;
      5'h11: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] m_status();
    return {m_flags, 20'h0, m_i, m_f, m_t, m_mode};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 5'h13; m_i = 1; m_f = 1; m_t = 0; m_flags = 0;
    for (int b = 0; b < 5; b++) begin m_lr[b] = '0; m_spsr[b] = '0; end
  endtask

  task automatic step(input logic rs, sw, un, pa, da, iq, fq, input logic [31:0] pc,
                      input logic we, input logic [31:0] wd, input logic bx,
                      input logic [31:0] bt);
    logic [6:0] rq;
    int win, b;
    logic [4:0] tm, vo;
    logic sf, e_load;
    logic [31:0] e_pc, old_st;
    string tag, ttag;
    req_rst = rs; req_swi = sw; req_und = un; req_pabt = pa; req_dabt = da; irq = iq; fiq = fq;
    pc_in = pc; sr_we = we; sr_wd = wd; bx_v = bx; bx_tgt = bt;
    rq = {sw, un, pa, iq & ~m_i, fq & ~m_f, da, rs};
    win = -1;
    for (int k = 0; k < 7; k++) if (rq[k] && win < 0) win = k;
    old_st = m_status();
    e_load = 0; e_pc = 0; sf = 0; tm = 0; vo = 0;
    ttag = bx ? "R12" : "R7";
    if (win >= 0) begin
      tag = ($countones(rq) > 1) ? "R4" : "R3";
      if (we || bx) tag = "R13";
      ttag = "R7";
      case (win)
        0: begin tm = 5'h13; vo = 5'h00; sf = 1; end
        1: begin tm = 5'h17; vo = 5'h10; end
        2: begin tm = 5'h11; vo = 5'h1C; sf = 1; end
        3: begin tm = 5'h12; vo = 5'h18; end
        4: begin tm = 5'h17; vo = 5'h0C; end
        5: begin tm = 5'h1B; vo = 5'h04; end
        default: begin tm = 5'h13; vo = 5'h08; end
      endcase
      b = bank(tm);
      m_lr[b] = pc - 32'd4;
      m_spsr[b] = old_st;
      m_mode = tm; m_i = 1; m_t = 0;
      if (sf) m_f = 1;
      e_load = 1; e_pc = {27'h0, vo};
    end else begin
      tag = "R3";
      if ((iq && m_i) || (fq && m_f)) tag = "R5";
      if (we) begin
        tag = (m_mode == 5'h10) ? "R10" : (!legal(wd[4:0]) ? "R11" : "R9");
        m_flags = wd[31:28];
        if (m_mode != 5'h10) begin
          m_i = wd[7]; m_f = wd[6];
          if (legal(wd[4:0])) m_mode = wd[4:0];
        end
      end
      if (bx) begin
        tag = we ? "R13" : "R12";
        m_t = bt[0];
        e_load = 1; e_pc = bt & ~32'h1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    b = bank(m_mode);
    check(tag, "mode", {27'h0, mode}, {27'h0, m_mode});
    check(tag, "status", status, m_status());
    check("R2", "priv", {31'h0, priv}, {31'h0, (m_mode != 5'h10)});
    check("R7", "masks", {30'h0, imask, fmask}, {30'h0, m_i, m_f});
    check(ttag, "thumb", {31'h0, thumb}, {31'h0, m_t});
    check("R6", "lr", lr, (b >= 0) ? m_lr[b] : 32'h0);
    check("R6", "spsr", spsr, (b >= 0) ? m_spsr[b] : 32'h0);
    check(bx && win < 0 ? "R12" : "R8", "pc_load", {31'h0, pc_load}, {31'h0, e_load});
    if (e_load) check(bx && win < 0 ? "R12" : "R8", "pc", pc_out, e_pc);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 0, 32'h0, 0, 32'h0);
  endtask

  task automatic wr(input logic [31:0] d);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 1, d, 0, 32'h0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] modes [8];
    logic [31:0] r;
    modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h15};
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "mode", {27'h0, mode}, 32'h13);
    check("R1", "status", status, 32'h0000_00D3);
    check("R1", "lr", lr, 32'h0);
    check("R1", "spsr", spsr, 32'h0);
    check("R1", "pc_load", {31'h0, pc_load}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // each kind alone, masks cleared first (R3 R6 R7 R8)
    wr(32'h0000_0013);
    step(0, 1, 0, 0, 0, 0, 0, 32'h100, 0, 0, 0, 0); wr(32'h5000_0013);
    step(0, 0, 1, 0, 0, 0, 0, 32'h204, 0, 0, 0, 0); wr(32'h0000_0013);
    step(0, 0, 0, 1, 0, 0, 0, 32'h308, 0, 0, 0, 0); wr(32'h0000_0013);
    step(0, 0, 0, 0, 1, 0, 0, 32'h40C, 0, 0, 0, 0); wr(32'h0000_0013);
    step(0, 0, 0, 0, 0, 1, 0, 32'h510, 0, 0, 0, 0); wr(32'h0000_0013);
    step(0, 0, 0, 0, 0, 0, 1, 32'h614, 0, 0, 0, 0); wr(32'h0000_0013);
    step(1, 0, 0, 0, 0, 0, 0, 32'h718, 0, 0, 0, 0);
    // R5 masked interrupts after reset entry
    step(0, 0, 0, 0, 0, 1, 1, 32'h800, 0, 0, 0, 0);
    // R9 reach system mode, then enter supervisor from it
    wr(32'hA000_001F);
    step(0, 1, 0, 0, 0, 0, 0, 32'h900, 0, 0, 0, 0);
    // R11 illegal mode value
    wr(32'h3000_0015);
    // R10 user mode writes
    wr(32'h0000_0010);
    wr(32'hF000_001F);
    wr(32'h0000_0013);
    // R4 all at once, and lower-priority pairs
    wr(32'h0000_0013);
    step(1, 1, 1, 1, 1, 1, 1, 32'hA00, 0, 0, 0, 0); wr(32'h0000_0013);
    step(0, 1, 1, 1, 1, 1, 1, 32'hA04, 0, 0, 0, 0); wr(32'h0000_0013);
    step(0, 1, 1, 1, 0, 1, 0, 32'hA08, 0, 0, 0, 0); wr(32'h0000_0013);
    step(0, 1, 1, 0, 0, 0, 0, 32'hA0C, 0, 0, 0, 0); wr(32'h0000_0013);
    // R12 branches
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_1235);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_2000);
    // R13 coincidence
    step(0, 1, 0, 0, 0, 0, 0, 32'hB00, 1, 32'h0000_001F, 1, 32'h0000_3001);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_001F, 1, 32'h0000_3001);
    idle();

    for (int n = 0; n < 4000; n++) begin
      logic rs, sw, un, pa, da, iq, fq, we, bx;
      logic [31:0] wd;
      r = $urandom;
      rs = ($urandom % 64) == 0;
      sw = ($urandom % 12) == 0; un = ($urandom % 14) == 0;
      pa = ($urandom % 14) == 0; da = ($urandom % 14) == 0;
      iq = ($urandom % 6) == 0;  fq = ($urandom % 8) == 0;
      we = ($urandom % 4) == 0;  bx = ($urandom % 6) == 0;
      wd = $urandom;
      wd[4:0] = modes[$urandom % 8];
      if ($urandom % 2) wd[7:6] = 2'b00;
      step(rs, sw, un, pa, da, iq, fq, r & 32'hFFFF_FFFC, we, wd, bx, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule